// File: doc/BRIEF.md
# Message Unit Inbound Interrupt Status Controller

This block keeps the inbound interrupt status word of a message-passing unit and turns it into two processor-facing lines. Queue logic sends single-cycle event pulses when the outbound free queue overflows, when the inbound post queue overflows, or when an external bus master posts a new message frame address. Doorbell logic supplies a steady level that stays high while its machine-check flag is set. Each event has a bit in a separate mask word. A set mask bit stops the event from ever reaching the status word. It does more than hide the resulting interrupt.

The two overflow flags and the doorbell condition drive a machine-check line. The posted-frame flag drives an ordinary interrupt line. Both lines are levels. Software reaches the status word and the mask word through a small register port. The port has a write strobe, a word address, write data, and combinational read data. The latched flags are cleared by writing 1 to them. The doorbell flag is a live copy of its input and cannot be written.

The status word is laid out as follows:

| Bit | Meaning |
|-----|---------|
| 8 | outbound free-queue overflow |
| 7 | inbound post-queue overflow |
| 5 | frame posted |
| 4 | doorbell machine check |

All other bits are zero. The mask word uses the same bit positions. The block holds no state machine. Its state is three sticky flag registers and one mask register.

Top module: `msg_irq_status_ctrl`

## Requirements
- R1: After reset, the status word (address `STATUS_OFS` = 0) and the mask word (address `MASK_OFS` = 1) read 0. Both `mcheck_o` and `irq_o` are low, as long as `db_mc_i` is low.
- R2: Bits 31..9, 6 and 3..0 of both words read 0. Writing ones to them changes nothing.
- R3: If a pulse arrives on `ev_outfree_ovf_i`, `ev_inpost_ovf_i` or `ev_post_i` while its mask bit is 0, status bit 8, 7 or 5 is set on the next clock edge. The bit stays set until it is cleared.
- R4: A pulse that arrives while its mask bit is 1 does not set its status bit.
- R5: Writing a 1 to status bit 8, 7 or 5 clears that bit on the clock edge of the write. Writing a 0 leaves it unchanged.
- R6: If an unmasked event and a write-1 clear of the same bit fall in the same cycle, the bit ends up set.
- R7: Status bit 4 reads as `db_mc_i AND NOT mask[4]`, in the same cycle. It has no memory, and writes to it have no effect.
- R8: `mcheck_o` is high exactly when status bit 8, 7 or 4 is 1.
- R9: `irq_o` is high exactly when status bit 5 is 1.
- R10: Setting a mask bit while its status bit is already set leaves that status bit set.
- R11: Mask bits 8, 7, 5 and 4 are read/write at `MASK_OFS` and hold their value until the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_wr_i | input | 1 | register write strobe |
| reg_addr_i | input | ADDR_W | word address of the register access |
| reg_wdata_i | input | 32 | write data |
| reg_rdata_o | output | 32 | read data for the addressed word, combinational |
| ev_outfree_ovf_i | input | 1 | outbound free-queue overflow pulse |
| ev_inpost_ovf_i | input | 1 | inbound post-queue overflow pulse |
| ev_post_i | input | 1 | new frame address posted pulse |
| db_mc_i | input | 1 | doorbell machine-check level |
| mcheck_o | output | 1 | machine-check request level |
| irq_o | output | 1 | ordinary interrupt request level |

## Verification
The assertions assume that inputs are settled at each rising edge. They also assume that a write whose address matches neither word does nothing. The bench drives every input on the falling edge. It picks addresses only from the two defined words and one unused word, and it drives event pulses and the doorbell level from a seeded random source. Write data is random across all 32 bits, so the reserved positions are exercised. Directed steps cover the set-versus-clear collision and masking a flag that is already set.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_LATCH = 3;
    localparam int POS_OFO   = 8;
    localparam int POS_IPO   = 7;
    localparam int POS_POST  = 5;
    localparam int POS_DMC   = 4;
    // latched flag positions, index 0..2
    localparam int LATCH_POS [NUM_LATCH] = '{POS_OFO, POS_IPO, POS_POST};
    localparam logic [DATA_W-1:0] MASK_WR_BITS =
        (DATA_W'(1) << POS_OFO) | (DATA_W'(1) << POS_IPO) |
        (DATA_W'(1) << POS_POST) | (DATA_W'(1) << POS_DMC);
endpackage

// File: rtl/msgirq_w1c_bit.sv
module msgirq_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/msgirq_mask_reg.sv
module msgirq_mask_reg
    import msgirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_i)
            mask_o <= wdata_i & MASK_WR_BITS;
    end

    // R11
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));
    // R2
    mask_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o & ~MASK_WR_BITS) == '0);
endmodule

// File: rtl/msgirq_out_gen.sv
module msgirq_out_gen
    import msgirq_pkg::*;
(
    input  logic [DATA_W-1:0] status_i,
    output logic              mcheck_o,
    output logic              irq_o
);
    always_comb begin
        mcheck_o = status_i[POS_OFO] | status_i[POS_IPO] | status_i[POS_DMC];
        irq_o    = status_i[POS_POST];
    end
endmodule

// File: rtl/msg_irq_status_ctrl.sv
module msg_irq_status_ctrl
    import msgirq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int STATUS_OFS = 0,
    parameter int MASK_OFS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              ev_outfree_ovf_i,
    input  logic              ev_inpost_ovf_i,
    input  logic              ev_post_i,
    input  logic              db_mc_i,
    output logic              mcheck_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

    logic                 sel_stat, sel_mask;
    logic [DATA_W-1:0]    mask_q;
    logic [DATA_W-1:0]    status_w;
    logic [NUM_LATCH-1:0] ev_vec;
    logic [NUM_LATCH-1:0] flag_q;

    assign sel_stat = (reg_addr_i == A_STAT);
    assign sel_mask = (reg_addr_i == A_MASK);
    assign ev_vec   = {ev_post_i, ev_inpost_ovf_i, ev_outfree_ovf_i};

    msgirq_mask_reg u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i && sel_mask),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_q)
    );

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_flag
        localparam int P = LATCH_POS[i];
        msgirq_w1c_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ev_vec[i] && !mask_q[P]),
            .clr_i (reg_wr_i && sel_stat && reg_wdata_i[P]),
            .q_o   (flag_q[i])
        );
    end

    always_comb begin
        status_w = '0;
        for (int k = 0; k < NUM_LATCH; k++)
            status_w[LATCH_POS[k]] = flag_q[k];
        status_w[POS_DMC] = db_mc_i && !mask_q[POS_DMC];
    end

    always_comb begin
        if (sel_stat)
            reg_rdata_o = status_w;
        else if (sel_mask)
            reg_rdata_o = mask_q;
        else
            reg_rdata_o = '0;
    end

    msgirq_out_gen u_out (
        .status_i (status_w),
        .mcheck_o (mcheck_o),
        .irq_o    (irq_o)
    );

    // R4
    masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_outfree_ovf_i && mask_q[POS_OFO] && !status_w[POS_OFO]) |=> !status_w[POS_OFO]);
    // R3
    post_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_post_i && !mask_q[POS_POST]) |=> irq_o);
    // R8
    doorbell_mcheck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mc_i && !mask_q[POS_DMC]) |-> mcheck_o);
    // R10
    mask_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[POS_IPO] && !(reg_wr_i && sel_stat)) |=> status_w[POS_IPO]);
endmodule

// File: tb/test_msg_irq_status_ctrl.sv
module test_msg_irq_status_ctrl;
    localparam logic [31:0] MW = 32'h0000_01B0;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        ev_of = 0, ev_ip = 0, ev_po = 0, db = 0;
    logic        mchk, irq;

    int checks = 0, errors = 0;
    logic [31:0] m_mask = 0;
    logic m8 = 0, m7 = 0, m5 = 0;

    always #5 clk = ~clk;

    msg_irq_status_ctrl i_msg_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ev_outfree_ovf_i(ev_of), .ev_inpost_ovf_i(ev_ip), .ev_post_i(ev_po),
        .db_mc_i(db), .mcheck_o(mchk), .irq_o(irq)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] s = 0;
        s[8] = m8; s[7] = m7; s[5] = m5;
        s[4] = db & ~m_mask[4];
        return s;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [31:0] es = exp_status();
        wr = 0;
        addr = 0; #1;
        chk({tag, " R2 R7 status"}, rdata, es);
        addr = 1; #1;
        chk({tag, " R11 mask"}, rdata, m_mask);
        addr = 2; #1;
        chk({tag, " unused word"}, rdata, 32'h0);
        chk({tag, " R8 mcheck"}, {31'h0, mchk}, {31'h0, es[8] | es[7] | es[4]});
        chk({tag, " R9 irq"}, {31'h0, irq}, {31'h0, es[5]});
    endtask

    // one clock step: drive at negedge, model update at posedge
    task automatic step(logic of, logic ip, logic po, logic d,
                        logic w, logic [3:0] a, logic [31:0] wd, string tag);
        logic c8, c7, c5;
        @(negedge clk);
        ev_of = of; ev_ip = ip; ev_po = po; db = d;
        wr = w; addr = a; wdata = wd;
        c8 = w && a == 0 && wd[8];
        c7 = w && a == 0 && wd[7];
        c5 = w && a == 0 && wd[5];
        @(posedge clk);
        #1;
        m8 = (of & ~m_mask[8]) | (m8 & ~c8);
        m7 = (ip & ~m_mask[7]) | (m7 & ~c7);
        m5 = (po & ~m_mask[5]) | (m5 & ~c5);
        if (w && a == 1) m_mask = wd & MW;
        ev_of = 0; ev_ip = 0; ev_po = 0;
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        #23;
        check_all("R1 in reset");
        rst_n = 1;
        check_all("R1 after reset");

        // R3 set each flag, R9/R8 outputs
        step(1, 0, 0, 0, 0, 0, 0, "R3 ofo");
        step(0, 1, 0, 0, 0, 0, 0, "R3 ipo");
        step(0, 0, 1, 0, 0, 0, 0, "R3 post");
        // R5 write zero has no effect, then clear with ones
        step(0, 0, 0, 0, 1, 0, 32'h0, "R5 write zero");
        step(0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, "R5 clear all R2");
        // R6 set wins over clear
        step(0, 0, 1, 0, 1, 0, 32'h20, "R6 collision");
        // R10 mask after set keeps flag
        step(0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, "R10 R11 R2 mask all");
        // R4 masked events do not set
        step(1, 1, 1, 1, 0, 0, 0, "R4 R7 masked");
        step(0, 0, 0, 0, 1, 0, 32'h1B0, "R5 R7 clear");
        // R7 doorbell unmasked, write ignored
        step(0, 0, 0, 1, 1, 1, 32'h0, "R7 unmask");
        step(0, 0, 0, 1, 1, 0, 32'h10, "R7 write ignored");
        step(0, 0, 0, 0, 0, 0, 0, "R7 no latch");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] r = $urandom;
            logic [31:0] wd = $urandom;
            logic [3:0]  a = 4'(r[9:8] == 2'd3 ? 2 : r[9:8]);
            if (r[12]) wd = wd & MW;
            step(r[0] & r[1], r[2] & r[3], r[4] & r[5], r[6],
                 r[7] & r[10], a, wd, "R3 R4 R5 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule